// File: doc/BRIEF.md
# Sixteen-bit Compare Timer with Event Interrupt

This block is a 16-bit up-counter that sits on a byte-wide register bus. An external count-enable input paces it, and one global halt bit can freeze it while software sets it up. Two compare channels watch every count step. Each one raises an event bit when the counter steps onto its programmed value. The block also raises an event when the counter wraps past its all-ones value. A rising edge on a capture input copies the counter into a capture register and raises a fourth event.

Each event bit is held in a sticky event register. Software clears a bit by writing 1 to it. An enable register selects which held events drive the single interrupt line. That line is registered and active high. Software reads the counter, the capture value and the compare values one byte at a time, and the low byte always sits at the lower address. The waveform outputs, the prescaler and the PWM modes are left to neighbouring logic. Two configuration bytes at 0x80 and 0x81 are kept as plain storage for that logic.

Top module: `cmp_timer16`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: The counter (low byte 0x84, high byte 0x85) adds one on each clock where `cnt_en` is high, the halt bit is clear and no counter byte is being written. It wraps from 0xFFFF to 0x0000.
- R3: While bit 7 of the sync register (0x43) is 1, the counter holds its value. Bit 7 reads back, and bits 6..0 of 0x43 always read 0.
- R4: Bit 0 of the event register (0x36) is set by a count step taken from 0xFFFF.
- R5: Bit 1 (channel A, 0x88 low / 0x89 high) and bit 2 (channel B, 0x8A low / 0x8B high) of 0x36 are set by a count step whose new counter value equals that channel's compare value. Equality reached without a step, whether by halting or by a software write, never sets them.
- R6: A rising edge of `cap_in`, seen after a two-stage synchronizer, copies the counter into the capture register (0x86 low / 0x87 high) and sets bit 5 of 0x36. Holding `cap_in` high does not set the bit again.
- R7: Writing 1 to an event bit clears it and writing 0 leaves it as it is. A hardware set in the same clock as a clear wins.
- R8: The enable register (0x6F) keeps bits 0, 1, 2 and 5, which match the event positions, and reads 0 elsewhere. `irq` is the registered OR of event AND enable, so it goes high one clock after the event bit.
- R9: A counter byte write replaces that byte and takes priority over a count step in the same clock. 0x80 and 0x81 read back what was written. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable from an external prescaler |
| cap_in | input | 1 | Capture event input (asynchronous) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
A counter that is off by one step shows up as a wrong counter readback in the same table row. It also appears as a missing or extra compare event, because compare events fire only on steps and the bench picks compare values one step before, exactly at, and one step past the run's end. An event register stuck set or wrongly cleared shows up on the next read of 0x36. It also reaches `irq` exactly one clock later, and the bench samples `irq` at both that clock and the one before it. A capture register that latches at the wrong moment reads back a value other than the frozen counter value.

// File: rtl/cmp_timer16_pkg.sv
package cmp_timer16_pkg;

   localparam int unsigned BUS_W = 8;

   // register addresses
   localparam logic [7:0] A_SYNC   = 8'h43;
   localparam logic [7:0] A_EVT    = 8'h36;
   localparam logic [7:0] A_ENA    = 8'h6F;
   localparam logic [7:0] A_CFG0   = 8'h80;
   localparam logic [7:0] A_CFG1   = 8'h81;
   localparam logic [7:0] A_CNT_LO = 8'h84;
   localparam logic [7:0] A_CNT_HI = 8'h85;
   localparam logic [7:0] A_CAP_LO = 8'h86;
   localparam logic [7:0] A_CAP_HI = 8'h87;
   localparam logic [7:0] A_CMP0   = 8'h88;

   // event bit positions
   localparam int unsigned B_WRAP = 0;
   localparam int unsigned B_CMP0 = 1;
   localparam int unsigned B_CAPT = 5;
   localparam int unsigned B_HALT = 7;

   // low-byte address of compare channel i
   function automatic logic [7:0] cmp_lo_addr(input int unsigned i);
      return 8'(int'(A_CMP0) + 2 * int'(i));
   endfunction

   // implemented event / enable bits for a given channel count
   function automatic logic [7:0] evt_impl(input int unsigned n_cmp);
      logic [7:0] m;
      m = 8'h00;
      m[B_WRAP] = 1'b1;
      m[B_CAPT] = 1'b1;
      for (int i = 0; i < int'(n_cmp); i++) m[B_CMP0 + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cmp_timer16_count.sv
module cmp_timer16_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt,
   output logic             step,
   output logic             wrap
);
   localparam int unsigned HI_W = CNT_W - 8;

   logic sw_wr;

   assign sw_wr = wr_lo | wr_hi;
   assign step  = adv & ~sw_wr;
   assign nxt   = cnt + 1'b1;
   assign wrap  = step & (&cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (sw_wr) begin
         if (wr_lo) cnt[7:0]       <= wdata;
         if (wr_hi) cnt[CNT_W-1:8] <= wdata[HI_W-1:0];
      end else if (step) begin
         cnt <= nxt;
      end
   end
endmodule

// File: rtl/cmp_timer16_match.sv
module cmp_timer16_match #(
   parameter int unsigned CNT_W   = 16,
   parameter logic [7:0]  LO_ADDR = 8'h88
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [7:0]       bus_wdata,
   input  logic             step,
   input  logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] cmp_val,
   output logic             hit
);
   localparam int unsigned HI_W    = CNT_W - 8;
   localparam logic [7:0]  HI_ADDR = LO_ADDR + 8'd1;

   logic wr_lo, wr_hi;

   assign wr_lo = bus_wr && (bus_addr == LO_ADDR);
   assign wr_hi = bus_wr && (bus_addr == HI_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val <= '0;
      end else begin
         if (wr_lo) cmp_val[7:0]       <= bus_wdata;
         if (wr_hi) cmp_val[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
      end
   end

   // only a real count step onto the value raises the event
   assign hit = step && (nxt == cmp_val);
endmodule

// File: rtl/cmp_timer16_capture.sv
module cmp_timer16_capture #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_val,
   output logic             evt
);
   logic lvl;
   logic lvl_q;

   generate
      if (SYNC == 0) begin : g_direct
         assign lvl = cap_in;
      end else begin : g_sync
         logic [SYNC-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= (chain << 1) | SYNC'(cap_in);
         end
         assign lvl = chain[SYNC-1];
      end
   endgenerate

   assign evt = lvl & ~lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         cap_val <= '0;
      end else begin
         lvl_q <= lvl;
         if (evt) cap_val <= cnt;
      end
   end
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
   import cmp_timer16_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned N_CMP    = 2,
   parameter int unsigned CAP_SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_en,
   input  logic       cap_in,
   input  logic [7:0] bus_addr,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   localparam logic [7:0] IMPL = evt_impl(N_CMP);

   generate
      if (CNT_W <= 8 || CNT_W > 16) begin : g_bad_cnt_w
         $error("cmp_timer16: CNT_W must be 9..16");
      end
      if (N_CMP < 1 || N_CMP > 4) begin : g_bad_n_cmp
         $error("cmp_timer16: N_CMP must be 1..4");
      end
      if (CAP_SYNC > 4) begin : g_bad_sync
         $error("cmp_timer16: CAP_SYNC must be 0..4");
      end
   endgenerate

   logic             halt_q;
   logic [7:0]       flags_q, mask_q, cfg0_q, cfg1_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, cap_val;
   logic             step, wrap, cap_evt, ctr_wr, wr_flag;
   logic             wr_cnt_lo, wr_cnt_hi;
   logic [N_CMP-1:0]            hit;
   logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
   logic [7:0]       set_v, flags_d;

   assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
   assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
   assign ctr_wr    = wr_cnt_lo | wr_cnt_hi;
   assign wr_flag   = bus_wr && (bus_addr == A_EVT);

   cmp_timer16_count #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (cnt_en & ~halt_q),
      .wr_lo (wr_cnt_lo),
      .wr_hi (wr_cnt_hi),
      .wdata (bus_wdata),
      .cnt   (cnt_q),
      .nxt   (cnt_nxt),
      .step  (step),
      .wrap  (wrap)
   );

   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
         cmp_timer16_match #(
            .CNT_W   (CNT_W),
            .LO_ADDR (cmp_lo_addr(i))
         ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_addr  (bus_addr),
            .bus_wr    (bus_wr),
            .bus_wdata (bus_wdata),
            .step      (step),
            .nxt       (cnt_nxt),
            .cmp_val   (cmp_val[i]),
            .hit       (hit[i])
         );
      end
   endgenerate

   cmp_timer16_capture #(.CNT_W(CNT_W), .SYNC(CAP_SYNC)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_in  (cap_in),
      .cnt     (cnt_q),
      .cap_val (cap_val),
      .evt     (cap_evt)
   );

   // event set vector and write-one-to-clear, set wins
   always_comb begin
      set_v = 8'h00;
      set_v[B_WRAP] = wrap;
      set_v[B_CAPT] = cap_evt;
      for (int i = 0; i < int'(N_CMP); i++) set_v[B_CMP0 + i] = hit[i];
      flags_d = (flags_q & ~(wr_flag ? bus_wdata : 8'h00)) | set_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         flags_q <= 8'h00;
         mask_q  <= 8'h00;
         cfg0_q  <= 8'h00;
         cfg1_q  <= 8'h00;
         irq     <= 1'b0;
      end else begin
         flags_q <= flags_d & IMPL;
         irq     <= |(flags_q & mask_q);
         if (bus_wr) begin
            case (bus_addr)
               A_SYNC: halt_q <= bus_wdata[B_HALT];
               A_ENA:  mask_q <= bus_wdata & IMPL;
               A_CFG0: cfg0_q <= bus_wdata;
               A_CFG1: cfg1_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // read mux
   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         A_SYNC:   bus_rdata = {halt_q, 7'b0};
         A_EVT:    bus_rdata = flags_q;
         A_ENA:    bus_rdata = mask_q;
         A_CFG0:   bus_rdata = cfg0_q;
         A_CFG1:   bus_rdata = cfg1_q;
         A_CNT_LO: bus_rdata = cnt_q[7:0];
         A_CNT_HI: bus_rdata = 8'(cnt_q >> 8);
         A_CAP_LO: bus_rdata = cap_val[7:0];
         A_CAP_HI: bus_rdata = 8'(cap_val >> 8);
         default:  ;
      endcase
      for (int i = 0; i < int'(N_CMP); i++) begin
         if (bus_addr == cmp_lo_addr(i))         bus_rdata = cmp_val[i][7:0];
         if (bus_addr == cmp_lo_addr(i) + 8'd1)  bus_rdata = 8'(cmp_val[i] >> 8);
      end
   end
endmodule

// File: rtl/cmp_timer16_chk.sv
module cmp_timer16_chk
   import cmp_timer16_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CMP = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic             wrap,
   input logic             halt,
   input logic             ctr_wr,
   input logic             cap_evt,
   input logic             wr_flag,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cap_val,
   input logic [7:0]       flags,
   input logic [7:0]       mask,
   input logic [7:0]       wdata
);
   localparam logic [7:0] IMPL = evt_impl(N_CMP);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt == CNT_W'($past(cnt) + 1'b1));

   assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !ctr_wr) |=> $stable(cnt));

   assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (flags[B_WRAP] && cnt == '0));

   assert_cmp_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[B_CMP0] && !step) |=> !flags[B_CMP0]);

   assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_val == $past(cnt) && flags[B_CAPT]));

   assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && wdata[B_WRAP] && !wrap) |=> !flags[B_WRAP]);

   assert_irq_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == |($past(flags & mask)));

   assert_mask_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask & ~IMPL) == 8'h00) && ((flags & ~IMPL) == 8'h00));
endmodule

bind cmp_timer16 cmp_timer16_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step    (step),
   .wrap    (wrap),
   .halt    (halt_q),
   .ctr_wr  (ctr_wr),
   .cap_evt (cap_evt),
   .wr_flag (wr_flag),
   .irq     (irq),
   .cnt     (cnt_q),
   .cap_val (cap_val),
   .flags   (flags_q),
   .mask    (mask_q),
   .wdata   (bus_wdata)
);

// File: tb/cmp_timer16_tb.sv
`timescale 1ns/1ps
module cmp_timer16_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cnt_en;
   logic       cap_in;
   logic [7:0] bus_addr;
   logic       bus_wr;
   logic [7:0] bus_wdata;
   wire  [7:0] bus_rdata;
   wire        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cmp_timer16 u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   // start, cmpA, cmpB, enable, steps, exp events, exp count, exp irq
   localparam logic [95:0] TBL [6] = '{
      {16'h0000, 16'h0003, 16'h0010, 8'h02, 8'd5, 8'h02, 16'h0005, 8'h01},
      {16'h0010, 16'h0011, 16'h0014, 8'h04, 8'd4, 8'h06, 16'h0014, 8'h01},
      {16'hFFFD, 16'h0001, 16'h0005, 8'h00, 8'd4, 8'h03, 16'h0001, 8'h00},
      {16'h1234, 16'h1234, 16'h1200, 8'h07, 8'd3, 8'h00, 16'h1237, 8'h00},
      {16'hFFFF, 16'h0000, 16'h0000, 8'h01, 8'd1, 8'h07, 16'h0000, 8'h01},
      {16'h00FE, 16'h0100, 16'h00FF, 8'h06, 8'd2, 8'h06, 16'h0100, 8'h01}
   };

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr16(input logic [7:0] a, input logic [15:0] d);
      wr(a, d[7:0]);
      wr(a + 8'd1, d[15:8]);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic rd16(input logic [7:0] a, output logic [15:0] d);
      logic [7:0] lo, hi;
      rd(a, lo);
      rd(a + 8'd1, hi);
      d = {hi, lo};
   endtask

   task automatic run(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] w;
      rst_n = 1'b0; cnt_en = 1'b0; cap_in = 1'b0;
      bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #0.5 chk("R1 irq", irq, 0);
      rd(8'h36, b);  chk("R1 events", b, 8'h00);
      rd(8'h6F, b);  chk("R1 enable", b, 8'h00);
      rd(8'h43, b);  chk("R1 sync", b, 8'h00);
      rd16(8'h84, w); chk("R1 counter", w, 16'h0000);
      rd16(8'h88, w); chk("R1 compare A", w, 16'h0000);

      // table walk: R2 R4 R5 R8
      for (int r = 0; r < 6; r++) begin
         logic [95:0] v;
         v = TBL[r];
         wr16(8'h88, v[79:64]);
         wr16(8'h8A, v[63:48]);
         wr16(8'h84, v[95:80]);
         wr(8'h36, 8'hFF);
         wr(8'h6F, v[47:40]);
         run(int'(v[39:32]));
         rd(8'h36, b);   chk($sformatf("R4/R5 row %0d events", r), b, v[31:24]);
         rd16(8'h84, w); chk($sformatf("R2 row %0d count", r), w, v[23:8]);
         chk($sformatf("R8 row %0d irq", r), irq, v[0]);
      end

      // R9 plain storage, enable mask, unmapped
      wr(8'h80, 8'h5A); wr(8'h81, 8'hA5);
      rd(8'h80, b); chk("R9 cfg0", b, 8'h5A);
      rd(8'h81, b); chk("R9 cfg1", b, 8'hA5);
      rd(8'h90, b); chk("R9 unmapped", b, 8'h00);
      wr(8'h6F, 8'hFF);
      rd(8'h6F, b); chk("R8 enable bits", b, 8'h27);
      wr(8'h6F, 8'h00);

      // R3 halt
      wr(8'h36, 8'hFF);
      wr16(8'h84, 16'h0100);
      wr(8'h43, 8'hFF);
      rd(8'h43, b); chk("R3 sync readback", b, 8'h80);
      run(10);
      rd16(8'h84, w); chk("R3 halted count", w, 16'h0100);
      wr(8'h43, 8'h00);
      run(3);
      rd16(8'h84, w); chk("R2 resumed count", w, 16'h0103);

      // R5 event only on the step onto the value
      wr16(8'h88, 16'h0105);
      run(2);
      rd(8'h36, b); chk("R5 compare A set", b, 8'h02);
      wr(8'h36, 8'h02);
      repeat (6) @(negedge clk);
      rd(8'h36, b); chk("R5 no reset while held", b, 8'h00);
      wr16(8'h84, 16'h0105);
      rd(8'h36, b); chk("R5 software equality", b, 8'h00);

      // R9 counter write wins over a step
      @(negedge clk);
      cnt_en = 1'b1; bus_addr = 8'h84; bus_wr = 1'b1; bus_wdata = 8'h20;
      @(negedge clk);
      cnt_en = 1'b0; bus_wr = 1'b0;
      rd16(8'h84, w); chk("R9 write beats step", w, 16'h0120);

      // R8 irq one clock after the event
      wr(8'h36, 8'hFF);
      wr(8'h6F, 8'h02);
      wr16(8'h88, 16'h0121);
      wr16(8'h84, 16'h0120);
      @(negedge clk);
      bus_addr = 8'h36; cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      #0.5;
      chk("R8 event same clock", bus_rdata, 8'h02);
      chk("R8 irq not yet", irq, 0);
      @(negedge clk);
      #0.5 chk("R8 irq next clock", irq, 1);

      // R7 set wins over clear, then write-one-to-clear
      wr(8'h6F, 8'h00);
      wr(8'h36, 8'hFF);
      wr16(8'h88, 16'h0122);
      @(negedge clk);
      cnt_en = 1'b1; bus_addr = 8'h36; bus_wr = 1'b1; bus_wdata = 8'h02;
      @(negedge clk);
      cnt_en = 1'b0; bus_wr = 1'b0;
      rd(8'h36, b); chk("R7 set wins", b, 8'h02);
      wr(8'h36, 8'h00);
      rd(8'h36, b); chk("R7 zero write keeps", b, 8'h02);
      wr(8'h36, 8'h02);
      rd(8'h36, b); chk("R7 one write clears", b, 8'h00);

      // R6 capture
      wr16(8'h84, 16'hABCD);
      wr(8'h6F, 8'h20);
      @(negedge clk); cap_in = 1'b1;
      repeat (6) @(negedge clk);
      rd(8'h36, b);   chk("R6 capture event", b, 8'h20);
      rd16(8'h86, w); chk("R6 capture value", w, 16'hABCD);
      chk("R6 capture irq", irq, 1);
      wr(8'h36, 8'h20);
      repeat (6) @(negedge clk);
      rd(8'h36, b);   chk("R6 level no re-event", b, 8'h00);
      cap_in = 1'b0;
      wr16(8'h84, 16'h1357);
      repeat (4) @(negedge clk);
      cap_in = 1'b1;
      repeat (6) @(negedge clk);
      rd16(8'h86, w); chk("R6 second capture", w, 16'h1357);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule